// File: doc/BRIEF.md
# Delay Window Centering Tuner

This block chooses the read-capture delay for a double-data-rate memory interface. It steps a delay-unit count through its range and, at every candidate, asks an external test engine to reinitialise the interface with that count, run an access test, and report pass or fail. The phase-select output stays at one fixed value during the whole run. Only the unit count moves.

Tuning has two stages. The coarse stage tests each count once, climbing from zero. It takes the first passing count as the low edge. The high edge is the last passing count before the next failing count, or the top of the range if no count fails. The confirmation stage then tests each edge a set number of times in a row. If any repeat fails, that edge moves one step toward the other edge and its confirmation starts over. When both edges are confirmed, the block presents the midpoint of the window and holds it until the next start. If no count passes, or the window shrinks to nothing, the block raises an error and presents no setting.

Top module: `dwin_tuner`

## Requirements
- R1: After reset, `done`, `error` and `test_req` are low and `unit_out` is zero.
- R2: `phase_sel` always equals the parameter `PHASE_SEL`, which is 1 by default.
- R3: After `start`, the coarse stage issues one test per count, in the order 0, 1, 2, and so on. The low edge is the first count that passes.
- R4: Once a low edge exists, the high edge is the count just below the first failing count. If every count up to the top of the range (2^`UNIT_W`-1) passes, the high edge is that top value.
- R5: Confirmation first proves the low edge and then the high edge. Each edge needs `REPEATS` consecutive passes (100 by default). A failed repeat raises the low edge by one, or lowers the high edge by one, and restarts the count for that edge.
- R6: On success, `done` rises and `unit_out` shows (low + high) >> 1, rounded down. Both stay unchanged until the next `start`.
- R7: If the whole range has no passing count, `error` rises, `done` stays low and `unit_out` is zero.
- R8: If an edge fails while the low and high edges are equal, `error` rises, `done` stays low and `unit_out` is zero.
- R9: `test_req` is a one-cycle pulse, and `unit_out` shows the count under test. That count holds from the request until the response. Only one test is outstanding at a time.
- R10: A `start` pulse received while tuning is in progress has no effect on the sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a tuning run (accepted only when not tuning) |
| test_rsp_vld | input | 1 | One-cycle pulse: the test result is valid |
| test_pass | input | 1 | Test outcome, sampled together with `test_rsp_vld` |
| test_req | output | 1 | One-cycle pulse asking for a test at `unit_out` |
| unit_out | output | UNIT_W | Candidate count while tuning; the midpoint when done; zero otherwise |
| phase_sel | output | PHASE_W | Fixed phase-select value for the delay line |
| done | output | 1 | Tuning succeeded; the result is valid on `unit_out` |
| error | output | 1 | Tuning failed; no setting is provided |

## Verification
The properties assume that the test engine sends exactly one `test_rsp_vld` pulse for each request, and only while that request is outstanding. They also assume that `start` is pulsed rather than held. The bench responder follows both rules: it answers each request once, after a latency of zero to two cycles. It raises `start` in the middle of a run once, on purpose, to show that it is ignored. The pass/fail model marks some counts as marginal. A marginal count passes its first two tests and then fails, so it survives the coarse stage but trips confirmation. The expected midpoints and test totals follow arithmetically from that model.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    localparam int DWT_UNIT_W_DEF  = 7;
    localparam int DWT_REPEATS_DEF = 100;
    localparam int DWT_PHASE_W_DEF = 4;
    localparam int DWT_PHASE_DEF   = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE,
        ST_ERR
    } dwt_state_t;

    typedef enum logic [1:0] {
        PH_SEEK_LO,
        PH_SEEK_HI,
        PH_PROVE_LO,
        PH_PROVE_HI
    } dwt_phase_t;

endpackage

// File: rtl/dwt_rep_cnt.sv
module dwt_rep_cnt #(
    parameter int REPEATS = dwt_pkg::DWT_REPEATS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(REPEATS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(REPEATS - 1));

endmodule

// File: rtl/dwt_mid.sv
module dwt_mid #(
    parameter int UNIT_W = dwt_pkg::DWT_UNIT_W_DEF
) (
    input  logic [UNIT_W-1:0] lo,
    input  logic [UNIT_W-1:0] hi,
    output logic [UNIT_W-1:0] mid
);
    logic [UNIT_W:0] sum;

    assign sum = {1'b0, lo} + {1'b0, hi};
    assign mid = sum[UNIT_W:1];

endmodule

// File: rtl/dwt_ctrl.sv
module dwt_ctrl
    import dwt_pkg::*;
#(
    parameter int UNIT_W = DWT_UNIT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rsp_vld,
    input  logic              rsp_pass,
    input  logic              rep_last,
    output logic              rep_inc,
    output logic              rep_clr,
    output dwt_state_t        st,
    output logic [UNIT_W-1:0] cand,
    output logic [UNIT_W-1:0] lo,
    output logic [UNIT_W-1:0] hi
);
    dwt_phase_t ph;
    logic       at_top;
    logic       rsp_here;
    logic       proving;

    assign at_top   = (cand == {UNIT_W{1'b1}});
    assign rsp_here = (st == ST_WAIT) && rsp_vld;
    assign proving  = (ph == PH_PROVE_LO) || (ph == PH_PROVE_HI);
    assign rep_inc  = rsp_here && proving && rsp_pass && !rep_last;
    assign rep_clr  = rsp_here && !rep_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            ph   <= PH_SEEK_LO;
            cand <= '0;
            lo   <= '0;
            hi   <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE, ST_ERR: begin
                    if (start) begin
                        st   <= ST_REQ;
                        ph   <= PH_SEEK_LO;
                        cand <= '0;
                        lo   <= '0;
                        hi   <= '0;
                    end
                end
                ST_REQ: st <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_vld) begin
                        st <= ST_REQ;
                        unique case (ph)
                            PH_SEEK_LO: begin
                                if (rsp_pass) begin
                                    lo <= cand;
                                    if (at_top) begin
                                        hi <= cand;
                                        ph <= PH_PROVE_LO;
                                    end else begin
                                        cand <= cand + 1'b1;
                                        ph   <= PH_SEEK_HI;
                                    end
                                end else if (at_top) begin
                                    st <= ST_ERR;
                                end else begin
                                    cand <= cand + 1'b1;
                                end
                            end
                            PH_SEEK_HI: begin
                                if (rsp_pass && !at_top) begin
                                    cand <= cand + 1'b1;
                                end else begin
                                    hi   <= rsp_pass ? cand : cand - 1'b1;
                                    cand <= lo;
                                    ph   <= PH_PROVE_LO;
                                end
                            end
                            PH_PROVE_LO: begin
                                if (rsp_pass) begin
                                    if (rep_last) begin
                                        ph   <= PH_PROVE_HI;
                                        cand <= hi;
                                    end
                                end else if (lo == hi) begin
                                    st <= ST_ERR;
                                end else begin
                                    lo   <= lo + 1'b1;
                                    cand <= lo + 1'b1;
                                end
                            end
                            PH_PROVE_HI: begin
                                if (rsp_pass) begin
                                    if (rep_last) st <= ST_DONE;
                                end else if (hi == lo) begin
                                    st <= ST_ERR;
                                end else begin
                                    hi   <= hi - 1'b1;
                                    cand <= hi - 1'b1;
                                end
                            end
                            default: st <= ST_ERR;
                        endcase
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dwin_tuner.sv
module dwin_tuner
    import dwt_pkg::*;
#(
    parameter int UNIT_W    = DWT_UNIT_W_DEF,
    parameter int REPEATS   = DWT_REPEATS_DEF,
    parameter int PHASE_W   = DWT_PHASE_W_DEF,
    parameter int PHASE_SEL = DWT_PHASE_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               test_rsp_vld,
    input  logic               test_pass,
    output logic               test_req,
    output logic [UNIT_W-1:0]  unit_out,
    output logic [PHASE_W-1:0] phase_sel,
    output logic               done,
    output logic               error
);
    dwt_state_t        st;
    logic [UNIT_W-1:0] cand;
    logic [UNIT_W-1:0] lo;
    logic [UNIT_W-1:0] hi;
    logic [UNIT_W-1:0] mid;
    logic              rep_last;
    logic              rep_inc;
    logic              rep_clr;

    dwt_ctrl #(.UNIT_W(UNIT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rsp_vld  (test_rsp_vld),
        .rsp_pass (test_pass),
        .rep_last (rep_last),
        .rep_inc  (rep_inc),
        .rep_clr  (rep_clr),
        .st       (st),
        .cand     (cand),
        .lo       (lo),
        .hi       (hi)
    );

    dwt_rep_cnt #(.REPEATS(REPEATS)) u_rep (
        .clk  (clk),
        .rst  (rst),
        .clr  (rep_clr),
        .inc  (rep_inc),
        .last (rep_last)
    );

    dwt_mid #(.UNIT_W(UNIT_W)) u_mid (
        .lo  (lo),
        .hi  (hi),
        .mid (mid)
    );

    always_comb begin
        unique case (st)
            ST_REQ, ST_WAIT: unit_out = cand;
            ST_DONE:         unit_out = mid;
            default:         unit_out = '0;
        endcase
    end

    assign test_req  = (st == ST_REQ);
    assign done      = (st == ST_DONE);
    assign error     = (st == ST_ERR);
    assign phase_sel = PHASE_W'(PHASE_SEL);

endmodule

// File: rtl/dwt_chk.sv
module dwt_chk #(
    parameter int UNIT_W = dwt_pkg::DWT_UNIT_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              test_req,
    input logic [UNIT_W-1:0] unit_out,
    input logic              done,
    input logic              error
);
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        test_req |=> !test_req); // R9

    AST_UNIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        test_req |=> $stable(unit_out)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(unit_out))); // R6

    AST_ERR_NO_SETTING: assert property (@(posedge clk) disable iff (rst)
        error |-> (unit_out == '0 && !done)); // R7

    AST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !test_req); // R8

endmodule

bind dwin_tuner dwt_chk #(.UNIT_W(UNIT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .test_req (test_req),
    .unit_out (unit_out),
    .done     (done),
    .error    (error)
);

// File: tb/sim_dwin_tuner.sv
module sim_dwin_tuner;
    localparam int UW   = 4;
    localparam int RP   = 3;
    localparam int TOPU = (1 << UW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          test_rsp_vld = 1'b0;
    logic          test_pass = 1'b0;
    logic          test_req;
    logic [UW-1:0] unit_out;
    logic [3:0]    phase_sel;
    logic          done;
    logic          error;

    int checks = 0;
    int errors = 0;
    int wd = 0;
    int hits [TOPU+1];

    always #4 clk = ~clk;

    dwin_tuner #(.UNIT_W(UW), .REPEATS(RP), .PHASE_W(4), .PHASE_SEL(1)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .test_rsp_vld(test_rsp_vld), .test_pass(test_pass),
        .test_req(test_req), .unit_out(unit_out), .phase_sel(phase_sel),
        .done(done), .error(error)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            errors++;
            $display("FAIL R9 watchdog: actual %0d cycles expected fewer", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Pass model: in window [wl,wh]; counts outside [sl,sh] are marginal
    // and fail from their third query on.
    task automatic run_case(input int wl, input int wh, input int sl, input int sh,
                            input bit exp_err, input int exp_mid, input int exp_reqs,
                            input int coarse_n, input bit poke, input string etag);
        int reqs = 0;
        int guard = 0;
        for (int i = 0; i <= TOPU; i++) hits[i] = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || error) && guard < 5000) begin
            if (test_req) begin
                int  u;
                bit  p;
                int  lat;
                u = int'(unit_out);
                chk(phase_sel == 4'd1, "R2 phase", int'(phase_sel), 1);
                if (reqs < coarse_n) chk(u == reqs, "R3 coarse order", u, reqs);
                p = (u >= wl && u <= wh) && ((u >= sl && u <= sh) || hits[u] < 2);
                hits[u]++;
                reqs++;
                lat = reqs % 3;
                @(negedge clk);
                chk(test_req == 1'b0, "R9 pulse", int'(test_req), 0);
                chk(int'(unit_out) == u, "R9 hold", int'(unit_out), u);
                if (poke && reqs == 4) start = 1'b1;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    start = 1'b0;
                end
                test_rsp_vld = 1'b1;
                test_pass = p;
                @(negedge clk);
                test_rsp_vld = 1'b0;
                test_pass = 1'b0;
                start = 1'b0;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        chk(error == exp_err, exp_err ? etag : "R6 no error", int'(error), int'(exp_err));
        chk(done == !exp_err, exp_err ? etag : "R6 done", int'(done), int'(!exp_err));
        if (exp_err) chk(unit_out == '0, etag, int'(unit_out), 0);
        else         chk(int'(unit_out) == exp_mid, "R6 midpoint", int'(unit_out), exp_mid);
        if (exp_reqs >= 0)
            chk(reqs == exp_reqs, poke ? "R10 ignored start" : "R3/R4/R5 test count",
                reqs, exp_reqs);
        repeat (2) @(negedge clk);
        chk(done == !exp_err && error == exp_err, "R6 hold", int'(done), int'(!exp_err));
    endtask

    function automatic int coarse_of(input int wh);
        return (wh < TOPU) ? wh + 2 : TOPU + 1;
    endfunction

    function automatic int reqs_of(input int wl, input int wh, input int sl, input int sh);
        return coarse_of(wh) + 2 * (sl - wl) + RP + 2 * (wh - sh) + RP;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !error && !test_req && unit_out == '0, "R1 reset",
            int'(done) + int'(error) + int'(test_req) + int'(unit_out), 0);
        chk(phase_sel == 4'd1, "R2 phase at reset", int'(phase_sel), 1);
        rst = 1'b0;
        @(negedge clk);

        // Stable windows of every position and width
        for (int a = 0; a <= TOPU; a++) begin
            for (int b = a; b <= TOPU; b++) begin
                run_case(a, b, a, b, 1'b0, (a + b) / 2, reqs_of(a, b, a, b),
                         coarse_of(b), 1'b0, "");
            end
        end
        // Marginal edges shrink the window (R5)
        for (int a = 0; a <= TOPU; a++) begin
            for (int b = a + 2; b <= TOPU; b++) begin
                run_case(a, b, a + 1, b - 1, 1'b0, (a + b) / 2,
                         reqs_of(a, b, a + 1, b - 1), coarse_of(b), 1'b0, "");
                if (b - a >= 4)
                    run_case(a, b, a + 2, b, 1'b0, (a + 2 + b) / 2,
                             reqs_of(a, b, a + 2, b), coarse_of(b), 1'b0, "");
            end
        end
        // No passing count anywhere (R7)
        run_case(1, 0, 1, 0, 1'b1, 0, TOPU + 1, TOPU + 1, 1'b0, "R7 empty range");
        // Window of marginal counts only collapses (R8)
        run_case(3, 7, 99, -1, 1'b1, 0, 9 + 10, 9, 1'b0, "R8 collapse");
        run_case(TOPU, TOPU, 99, -1, 1'b1, 0, TOPU + 1 + 2, TOPU + 1, 1'b0, "R8 top collapse");
        // Recovery after an error, and start ignored mid-run (R10)
        run_case(5, 11, 6, 10, 1'b0, 8, reqs_of(5, 11, 6, 10), coarse_of(11), 1'b1, "");
        run_case(0, TOPU, 0, TOPU, 1'b0, TOPU / 2, reqs_of(0, TOPU, 0, TOPU),
                 coarse_of(TOPU), 1'b1, "");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule